// File: doc/BRIEF.md
# Duty-Cycled Power Sequencing Controller

This block is a small Moore state machine that switches the power enables of three parts of a low-power sensing node: a processor, a sensor and a radio. A slow periodic wake clock, which is asynchronous to the fast system clock, marks the start of each work period. That clock is brought into the fast domain by a synchronizer, and an edge detector turns its rising edge into a one-cycle start pulse. On a start, the processor and the sensor are powered and a 2-bit temperature class is captured. The captured class then chooses how the period ends.

After the processor reports that it has finished, one of two things happens. For the normal and body-temperature classes, the radio is powered and the processor and the sensor stay on until the radio reports that its transmission is complete. For the night class, and for the unused code, everything powers off at once. The body-temperature class also raises an alert flag when the transmission completes. The flag is held until the next period starts. A kill input overrides everything and drops all three enables on the next clock edge.

All outputs are registered. The sensor enable always follows the processor enable.

Top module: `psc_pwr_ctrl`

## Requirements
- R1: While the synchronous reset is high, and on the first sample after it, all three power enables and the alert flag are 0.
- R2: When the slow clock is first sampled high at fast edge k, with the controller idle and kill low, the processor and sensor enables go to 1 after edge k+SYNC_STAGES and not before. The sensor enable always equals the processor enable.
- R3: The temperature class is captured on the edge that starts a period. Later changes to the temperature input have no effect until the next period.
- R4: Class 01 (normal): done from the processor turns the radio on at the next edge, while the processor and sensor stay on. Transmit-done then turns all three off at the next edge. The alert flag stays 0.
- R5: Class 10 (night) and class 00 (unused): done turns all three enables off at the next edge, and the radio is never powered.
- R6: Class 11 (body): the path is the same as R4. In addition, the alert flag goes to 1 on the same edge that removes power after transmit-done.
- R7: Once set, the alert flag stays 1 through idle time and kill. It clears only on reset or on the edge that starts the next period.
- R8: Kill high at an edge forces all three enables to 0 after that edge and returns the controller to idle. A slow-clock rising edge seen while kill is high is discarded, and the controller waits for the next one.
- R9: These inputs are ignored: a slow-clock rising edge during an active period, done while idle, and transmit-done while waiting for done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast system clock |
| rst | input | 1 | Synchronous active-high reset |
| wake_clk_i | input | 1 | Slow periodic wake clock, asynchronous |
| temp_class_i | input | 2 | Temperature class (00 unused, 01 normal, 10 night, 11 body) |
| proc_done_i | input | 1 | Processor has finished its work |
| radio_tx_done_i | input | 1 | Radio has finished transmitting |
| kill_i | input | 1 | Forces all power off |
| proc_pwr_o | output | 1 | Processor power enable |
| sensor_pwr_o | output | 1 | Sensor power enable |
| radio_pwr_o | output | 1 | Radio power enable |
| alert_o | output | 1 | Alert flag for the body-temperature class |

## Verification
The hardest situation to reach from the ports is a kill that coincides with the single-cycle start pulse. That pulse exists only SYNC_STAGES edges after the wake clock rises, so a kill placed by hand easily misses it. The directed stimulus therefore holds kill high across the whole synchronizer window, and then shows that releasing kill does not bring back the lost start. A long random phase toggles the wake clock and fires short kill pulses at random points. A behavioural reference model with a queue of wake-clock samples checks every cycle, which covers kills that land on the start pulse, on the done edge and on the transmit-done edge.

// File: rtl/psc_pkg.sv
package psc_pkg;

  localparam int TEMP_W = 2;

  typedef enum logic [1:0] {
    SEQ_IDLE     = 2'd0,
    SEQ_COMPUTE  = 2'd1,
    SEQ_TRANSMIT = 2'd2
  } seq_state_t;

  typedef enum logic [TEMP_W-1:0] {
    TC_UNUSED = 2'd0,
    TC_NORMAL = 2'd1,
    TC_NIGHT  = 2'd2,
    TC_BODY   = 2'd3
  } temp_class_t;

  typedef struct packed {
    logic proc;
    logic sensor;
    logic radio;
  } pwr_vec_t;

  function automatic logic class_uses_radio(temp_class_t c);
    return (c == TC_NORMAL) || (c == TC_BODY);
  endfunction

  function automatic logic class_raises_alert(temp_class_t c);
    return c == TC_BODY;
  endfunction

  function automatic pwr_vec_t state_power(seq_state_t s);
    pwr_vec_t p;
    p = '0;
    unique case (s)
      SEQ_COMPUTE:  begin p.proc = 1'b1; p.sensor = 1'b1; end
      SEQ_TRANSMIT: begin p.proc = 1'b1; p.sensor = 1'b1; p.radio = 1'b1; end
      default:      p = '0;
    endcase
    return p;
  endfunction

endpackage

// File: rtl/psc_edge_sync.sv
module psc_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic async_i,
  output logic rise_o
);
  localparam int LAST = STAGES - 1;

  logic [LAST:0] chain_q;
  logic          prev_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      chain_q <= '0;
      prev_q  <= 1'b0;
    end else begin
      chain_q <= {chain_q[LAST-1:0], async_i};
      prev_q  <= chain_q[LAST];
    end
  end

  assign rise_o = chain_q[LAST] & ~prev_q;

endmodule

// File: rtl/psc_class_latch.sv
module psc_class_latch
  import psc_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              load_i,
  input  logic [TEMP_W-1:0] class_i,
  output logic              uses_radio_o,
  output logic              raises_alert_o
);
  temp_class_t class_q;

  always_ff @(posedge clk) begin
    if (rst)         class_q <= TC_UNUSED;
    else if (load_i) class_q <= temp_class_t'(class_i);
  end

  assign uses_radio_o   = class_uses_radio(class_q);
  assign raises_alert_o = class_raises_alert(class_q);

endmodule

// File: rtl/psc_seq_fsm.sv
module psc_seq_fsm
  import psc_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  logic     kill_i,
  input  logic     start_i,
  input  logic     done_i,
  input  logic     tx_done_i,
  input  logic     uses_radio_i,
  input  logic     raises_alert_i,
  output logic     load_o,
  output pwr_vec_t pwr_o,
  output logic     alert_o
);
  seq_state_t state_q, state_n;
  pwr_vec_t   pwr_q;
  logic       alert_q, alert_n;
  logic       finish_tx;

  assign load_o    = (state_q == SEQ_IDLE) && start_i && !kill_i;
  assign finish_tx = (state_q == SEQ_TRANSMIT) && tx_done_i;

  always_comb begin
    state_n = state_q;
    if (kill_i) begin
      state_n = SEQ_IDLE;
    end else begin
      unique case (state_q)
        SEQ_IDLE:     if (start_i) state_n = SEQ_COMPUTE;
        SEQ_COMPUTE:  if (done_i)  state_n = uses_radio_i ? SEQ_TRANSMIT : SEQ_IDLE;
        SEQ_TRANSMIT: if (tx_done_i) state_n = SEQ_IDLE;
        default:      state_n = SEQ_IDLE;
      endcase
    end
  end

  always_comb begin
    alert_n = alert_q;
    if (!kill_i) begin
      if (load_o)                           alert_n = 1'b0;
      else if (finish_tx && raises_alert_i) alert_n = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= SEQ_IDLE;
      pwr_q   <= '0;
      alert_q <= 1'b0;
    end else begin
      state_q <= state_n;
      pwr_q   <= state_power(state_n);
      alert_q <= alert_n;
    end
  end

  assign pwr_o   = pwr_q;
  assign alert_o = alert_q;

endmodule

// File: rtl/psc_pwr_ctrl.sv
module psc_pwr_ctrl
  import psc_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wake_clk_i,
  input  logic [TEMP_W-1:0] temp_class_i,
  input  logic              proc_done_i,
  input  logic              radio_tx_done_i,
  input  logic              kill_i,
  output logic              proc_pwr_o,
  output logic              sensor_pwr_o,
  output logic              radio_pwr_o,
  output logic              alert_o
);
  logic     wake_rise;
  logic     load_class;
  logic     uses_radio;
  logic     raises_alert;
  pwr_vec_t pwr;

  psc_edge_sync #(.STAGES(SYNC_STAGES)) wake_sync_i (
    .clk     (clk),
    .rst     (rst),
    .async_i (wake_clk_i),
    .rise_o  (wake_rise)
  );

  psc_class_latch class_i (
    .clk            (clk),
    .rst            (rst),
    .load_i         (load_class),
    .class_i        (temp_class_i),
    .uses_radio_o   (uses_radio),
    .raises_alert_o (raises_alert)
  );

  psc_seq_fsm fsm_i (
    .clk            (clk),
    .rst            (rst),
    .kill_i         (kill_i),
    .start_i        (wake_rise),
    .done_i         (proc_done_i),
    .tx_done_i      (radio_tx_done_i),
    .uses_radio_i   (uses_radio),
    .raises_alert_i (raises_alert),
    .load_o         (load_class),
    .pwr_o          (pwr),
    .alert_o        (alert_o)
  );

  assign proc_pwr_o   = pwr.proc;
  assign sensor_pwr_o = pwr.sensor;
  assign radio_pwr_o  = pwr.radio;

endmodule

// File: rtl/psc_pwr_ctrl_chk.sv
module psc_pwr_ctrl_chk (
  input logic clk,
  input logic rst,
  input logic proc_done_i,
  input logic radio_tx_done_i,
  input logic kill_i,
  input logic proc_pwr_o,
  input logic sensor_pwr_o,
  input logic radio_pwr_o,
  input logic alert_o
);
  // R2
  sensor_follows_proc_chk: assert property (@(posedge clk) disable iff (rst)
    sensor_pwr_o == proc_pwr_o);

  // R4
  radio_needs_proc_chk: assert property (@(posedge clk) disable iff (rst)
    radio_pwr_o |-> proc_pwr_o);

  // R4
  radio_after_done_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(radio_pwr_o) |-> $past(proc_done_i) && $past(proc_pwr_o));

  // R6
  alert_after_tx_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(alert_o) |-> $past(radio_pwr_o) && $past(radio_tx_done_i) && !proc_pwr_o);

  // R7
  alert_clear_at_start_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(alert_o) |-> $rose(proc_pwr_o));

  // R8
  kill_drops_power_chk: assert property (@(posedge clk) disable iff (rst)
    kill_i |=> !proc_pwr_o && !sensor_pwr_o && !radio_pwr_o);

  // R8
  kill_keeps_alert_chk: assert property (@(posedge clk) disable iff (rst)
    kill_i |=> $stable(alert_o));

endmodule

bind psc_pwr_ctrl psc_pwr_ctrl_chk pwr_chk_i (
  .clk             (clk),
  .rst             (rst),
  .proc_done_i     (proc_done_i),
  .radio_tx_done_i (radio_tx_done_i),
  .kill_i          (kill_i),
  .proc_pwr_o      (proc_pwr_o),
  .sensor_pwr_o    (sensor_pwr_o),
  .radio_pwr_o     (radio_pwr_o),
  .alert_o         (alert_o)
);

// File: tb/psc_pwr_ctrl_tb_top.sv
module psc_pwr_ctrl_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int SYNC       = 2;
  localparam int WATCHDOG   = 150000;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       wake = 1'b0;
  logic [1:0] temp = 2'd0;
  logic       done = 1'b0;
  logic       txd  = 1'b0;
  logic       kill = 1'b0;
  logic       proc_pwr, sensor_pwr, radio_pwr, alert;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  psc_pwr_ctrl #(.SYNC_STAGES(SYNC)) dut_i (
    .clk             (clk),
    .rst             (rst),
    .wake_clk_i      (wake),
    .temp_class_i    (temp),
    .proc_done_i     (done),
    .radio_tx_done_i (txd),
    .kill_i          (kill),
    .proc_pwr_o      (proc_pwr),
    .sensor_pwr_o    (sensor_pwr),
    .radio_pwr_o     (radio_pwr),
    .alert_o         (alert)
  );

  // behavioural reference: 0 idle, 1 computing, 2 transmitting
  int   m_phase = 0;
  int   m_class = 0;
  bit   m_alert = 0;
  bit   wake_hist[$];

  always @(posedge clk) begin
    bit rise;
    if (rst) begin
      m_phase = 0; m_class = 0; m_alert = 0;
      wake_hist.delete();
      for (int i = 0; i <= SYNC; i++) wake_hist.push_back(1'b0);
    end else begin
      rise = wake_hist[SYNC-1] && !wake_hist[SYNC];
      if (kill) m_phase = 0;
      else if (m_phase == 0) begin
        if (rise) begin m_phase = 1; m_class = int'(temp); m_alert = 0; end
      end else if (m_phase == 1) begin
        if (done) m_phase = (m_class == 1 || m_class == 3) ? 2 : 0;
      end else if (txd) begin
        if (m_class == 3) m_alert = 1;
        m_phase = 0;
      end
      wake_hist.push_front(wake);
      void'(wake_hist.pop_back());
    end
  end

  task automatic chk(string tag, string what, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual %0b expected %0b at %0t", tag, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    cycles++;
    if (!rst) begin
      chk("R2", "proc_pwr model", proc_pwr, m_phase != 0);
      chk("R2", "sensor_pwr model", sensor_pwr, m_phase != 0);
      chk("R4", "radio_pwr model", radio_pwr, m_phase == 2);
      chk("R6", "alert model", alert, m_alert);
    end
    if (cycles > WATCHDOG) begin
      errors++;
      $display("FAIL watchdog expired actual %0d expected <= %0d", cycles, WATCHDOG);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  // raises wake, checks the start latency, lowers wake again
  task automatic start_period(logic [1:0] cls);
    temp = cls;
    wake = 1'b1;
    tick(SYNC);
    chk("R2", "proc before latency", proc_pwr, 1'b0);
    tick(1);
    chk("R2", "proc after latency", proc_pwr, 1'b1);
    chk("R2", "sensor after latency", sensor_pwr, 1'b1);
    chk("R7", "alert cleared at start", alert, 1'b0);
    wake = 1'b0;
    tick(SYNC + 2);
  endtask

  task automatic pulse_done();
    done = 1'b1; tick(1); done = 1'b0;
  endtask

  task automatic pulse_tx();
    txd = 1'b1; tick(1); txd = 1'b0;
  endtask

  initial begin
    tick(1);
    chk("R1", "proc in reset", proc_pwr, 1'b0);
    chk("R1", "radio in reset", radio_pwr, 1'b0);
    tick(2);
    rst = 1'b0;
    tick(1);
    chk("R1", "proc after reset", proc_pwr, 1'b0);
    chk("R1", "alert after reset", alert, 1'b0);

    // R4 normal class
    start_period(2'd1);
    pulse_done();
    chk("R4", "radio on after done", radio_pwr, 1'b1);
    chk("R4", "proc held during tx", proc_pwr, 1'b1);
    tick(3);
    pulse_tx();
    chk("R4", "proc off after tx", proc_pwr, 1'b0);
    chk("R4", "radio off after tx", radio_pwr, 1'b0);
    chk("R4", "no alert normal", alert, 1'b0);

    // R5 night and unused
    start_period(2'd2);
    pulse_done();
    chk("R5", "night proc off", proc_pwr, 1'b0);
    chk("R5", "night radio off", radio_pwr, 1'b0);
    start_period(2'd0);
    pulse_done();
    chk("R5", "unused proc off", proc_pwr, 1'b0);
    chk("R5", "unused radio off", radio_pwr, 1'b0);

    // R3 class changes after capture
    start_period(2'd2);
    temp = 2'd3;
    pulse_done();
    chk("R3", "late class ignored radio", radio_pwr, 1'b0);
    chk("R3", "late class ignored proc", proc_pwr, 1'b0);

    // R6 body class, R7 alert holds, R8 kill keeps alert
    start_period(2'd3);
    pulse_done();
    chk("R6", "body radio on", radio_pwr, 1'b1);
    chk("R6", "no alert before tx", alert, 1'b0);
    pulse_tx();
    chk("R6", "alert set", alert, 1'b1);
    chk("R6", "proc off after tx", proc_pwr, 1'b0);
    kill = 1'b1; tick(2); kill = 1'b0;
    tick(5);
    chk("R7", "alert held idle", alert, 1'b1);
    start_period(2'd2);
    pulse_done();

    // R8 kill during compute and during transmit
    start_period(2'd1);
    kill = 1'b1; tick(1); kill = 1'b0;
    chk("R8", "kill in compute", proc_pwr, 1'b0);
    pulse_done();
    chk("R8", "idle after kill ignores done", radio_pwr, 1'b0);
    start_period(2'd3);
    pulse_done();
    kill = 1'b1; tick(1);
    chk("R8", "kill in transmit radio", radio_pwr, 1'b0);
    chk("R8", "kill in transmit proc", proc_pwr, 1'b0);
    txd = 1'b1; tick(1); txd = 1'b0; kill = 1'b0;
    tick(1);
    chk("R8", "no alert after killed tx", alert, 1'b0);

    // R8 start lost while kill held
    kill = 1'b1; temp = 2'd1; wake = 1'b1;
    tick(SYNC + 3);
    kill = 1'b0;
    tick(4);
    chk("R8", "start lost under kill", proc_pwr, 1'b0);
    wake = 1'b0; tick(SYNC + 2);

    // R9 ignored inputs
    pulse_done();
    chk("R9", "done in idle ignored", proc_pwr, 1'b0);
    start_period(2'd1);
    pulse_tx();
    chk("R9", "tx in compute ignored", proc_pwr, 1'b1);
    chk("R9", "tx in compute radio", radio_pwr, 1'b0);
    wake = 1'b1; tick(SYNC + 3); wake = 1'b0; tick(SYNC + 2);
    chk("R9", "second rise ignored", proc_pwr, 1'b1);
    pulse_done();
    chk("R9", "path intact after rise", radio_pwr, 1'b1);
    pulse_tx();

    // random stress compared against the model every cycle
    for (int i = 0; i < 4000; i++) begin
      if (($urandom % 23) == 0) wake = ~wake;
      temp = 2'($urandom);
      done = (($urandom % 6) == 0);
      txd  = (($urandom % 5) == 0);
      kill = (($urandom % 47) == 0);
      tick(1);
    end
    done = 1'b0; txd = 1'b0; kill = 1'b0;
    tick(4);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule